// File: doc/BRIEF.md
# Sub-word Lane Memory Port

This block is a small data memory organised as rows of eight bytes. It serves loads and stores of one, two, four or eight bytes at a byte address. The low three address bits select a byte lane inside a row and the upper bits select the row. A narrow load picks the addressed lane out of the row and returns it zero-extended. A narrow store reads the row, replaces only the addressed lane and writes the row back, all in one cycle.

Each access can ask for its bytes to be reversed within its own width. A store reverses the data before merging it, and a load reverses it after extraction. An access whose offset is not a multiple of its width is refused: nothing is written, no load data is returned, and an error pulse appears instead. All rows clear to zero on reset.

Top module: `lane_mem_port`

## Requirements
- R1: The byte address splits into a row index (address shifted right by 3) and a byte offset (address bits [2:0]). Rows are independent: a store changes no other row.
- R2: An access is legal only when offset AND (width-1) is zero. An illegal access raises `align_err` for exactly the cycle after the request, writes nothing and does not assert `rd_valid`.
- R3: A legal load raises `rd_valid` in the cycle after the request, with its result on `rd_data`. While `rd_valid` is low, `rd_data` is zero.
- R4: A narrow load returns the bytes at offset..offset+width-1 of the row in `rd_data` bits [8*width-1:0], with zeros above. Size encoding: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is 8 bytes.
- R5: A narrow store writes `wr_data` byte i to row byte offset+i for i below the width, and leaves every other byte of the row unchanged.
- R6: A load issued in the cycle directly after a store to the same row returns the merged row contents.
- R7: With `req_swap` high, a store writes `wr_data` byte (width-1-i) to row byte offset+i.
- R8: With `req_swap` high, a load returns row byte offset+i in result byte (width-1-i).
- R9: After reset every row reads as zero, and `rd_valid`, `rd_data` and `align_err` are zero.
- R10: An 8-byte access writes or returns the whole row. With swap it reverses all eight bytes.
- R11: Bits of `wr_data` above the access width have no effect on the stored row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 for store, 0 for load |
| req_addr | input | ADDR_W (7) | Byte address |
| req_size | input | 2 | Access width code: 0=1B, 1=2B, 2=4B, 3=8B |
| req_swap | input | 1 | Reverse bytes within the access width |
| wr_data | input | 64 | Store data, low-order bytes used |
| rd_data | output | 64 | Load result, zero when rd_valid is low |
| rd_valid | output | 1 | Load result valid |
| align_err | output | 1 | Pulse for a refused misaligned access |

## Verification
A wrong lane shift, mask or byte reversal inside the merge corrupts a row without any immediate sign at the ports. It only becomes visible when a later load reads the damaged row, so the bench follows every store pattern with full-row and narrow reads of the same row. A flaw in load extraction or in the alignment decode shows one cycle after the request, on `rd_data`, `rd_valid` or `align_err`. A reference model that works byte by byte predicts each response, so a fault is reported at the first access whose response it changes.

// File: rtl/lane_mem_pkg.sv
package lane_mem_pkg;

    localparam int ROW_BYTES = 8;
    localparam int DATA_W    = ROW_BYTES * 8;
    localparam int OFF_W     = $clog2(ROW_BYTES);

    typedef logic [DATA_W-1:0] row_t;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic [OFF_W-1:0] off;
        acc_size_e        size;
        logic             swap;
    } lane_sel_t;

    function automatic int size_bytes(acc_size_e s);
        return 1 << int'(s);
    endfunction

    // ones over the low width*8 bits; the full row for an 8-byte access
    function automatic row_t width_mask(acc_size_e s);
        if (s == SZ_DWORD) return '1;
        return (row_t'(1) << (size_bytes(s) * 8)) - row_t'(1);
    endfunction

    // reverse the low size_bytes(s) bytes, clear the rest
    function automatic row_t rev_bytes(row_t v, acc_size_e s);
        row_t r;
        int   nb;
        nb = size_bytes(s);
        r  = '0;
        for (int i = 0; i < ROW_BYTES; i++) begin
            if (i < nb) r[i*8 +: 8] = v[(nb-1-i)*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/lane_addr_split.sv
module lane_addr_split
    import lane_mem_pkg::*;
#(
    parameter int ROW_W = 4,
    localparam int ADDR_W = ROW_W + OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  acc_size_e         size,
    output logic [ROW_W-1:0]  row_idx,
    output logic [OFF_W-1:0]  off,
    output logic              legal
);
    logic [OFF_W-1:0] low_bits;

    always_comb begin
        row_idx  = addr[ADDR_W-1:OFF_W];
        off      = addr[OFF_W-1:0];
        low_bits = OFF_W'(size_bytes(size) - 1);
        legal    = ((off & low_bits) == '0);
    end
endmodule

// File: rtl/lane_load_extract.sv
module lane_load_extract
    import lane_mem_pkg::*;
(
    input  row_t      row,
    input  lane_sel_t sel,
    output row_t      data
);
    row_t lane;
    int   sh;

    always_comb begin
        sh = int'(sel.off) * 8;
        if (sel.size == SZ_DWORD) lane = row;
        else lane = (row & (width_mask(sel.size) << sh)) >> sh;
        data = sel.swap ? rev_bytes(lane, sel.size) : lane;
    end
endmodule

// File: rtl/lane_store_merge.sv
module lane_store_merge
    import lane_mem_pkg::*;
(
    input  row_t      row,
    input  row_t      wdata,
    input  lane_sel_t sel,
    output row_t      merged
);
    row_t ins;
    row_t msk;
    int   sh;

    always_comb begin
        sh  = int'(sel.off) * 8;
        msk = width_mask(sel.size);
        ins = wdata & msk;
        if (sel.swap) ins = rev_bytes(ins, sel.size);
        if (sel.size == SZ_DWORD) merged = ins;
        else merged = (row & ~(msk << sh)) | (ins << sh);
    end
endmodule

// File: rtl/lane_mem_port.sv
module lane_mem_port
    import lane_mem_pkg::*;
#(
    parameter int ROWS = 16,
    localparam int ROW_W  = $clog2(ROWS),
    localparam int ADDR_W = ROW_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_swap,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              align_err
);
    row_t             rows [ROWS];
    logic [ROW_W-1:0] row_idx;
    logic [OFF_W-1:0] off;
    logic             legal;
    lane_sel_t        sel;
    row_t             cur_row;
    row_t             ld_data;
    row_t             st_row;
    logic             do_store;
    logic             do_load;

    lane_addr_split #(.ROW_W(ROW_W)) u_split (
        .addr    (req_addr),
        .size    (acc_size_e'(req_size)),
        .row_idx (row_idx),
        .off     (off),
        .legal   (legal)
    );

    always_comb begin
        sel.off  = off;
        sel.size = acc_size_e'(req_size);
        sel.swap = req_swap;
        cur_row  = rows[row_idx];
        do_store = req_valid && req_write && legal;
        do_load  = req_valid && !req_write && legal;
    end

    lane_load_extract u_load (
        .row  (cur_row),
        .sel  (sel),
        .data (ld_data)
    );

    lane_store_merge u_store (
        .row    (cur_row),
        .wdata  (wr_data),
        .sel    (sel),
        .merged (st_row)
    );

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst) rows[g] <= '0;
            else if (do_store && (row_idx == ROW_W'(g))) rows[g] <= st_row;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data   <= '0;
            rd_valid  <= 1'b0;
            align_err <= 1'b0;
        end else begin
            rd_data   <= do_load ? ld_data : '0;
            rd_valid  <= do_load;
            align_err <= req_valid && !legal;
        end
    end
endmodule

// File: rtl/lane_mem_port_chk.sv
module lane_mem_port_chk
    import lane_mem_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [OFF_W-1:0]  req_off,
    input logic [1:0]        req_size,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              align_err
);
    logic aligned;
    assign aligned = ((req_off & (OFF_W'((1 << req_size) - 1))) == '0);

    // R3
    load_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && aligned) |=> (rd_valid && !align_err));

    // R2
    misalign_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !aligned) |=> (align_err && !rd_valid));

    // R3
    idle_data_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (rd_data == '0));

    // R2
    no_req_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!align_err && !rd_valid));

    // R2
    excl_out_chk: assert property (@(posedge clk) disable iff (rst)
        !(align_err && rd_valid));
endmodule

bind lane_mem_port lane_mem_port_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_off   (req_addr[lane_mem_pkg::OFF_W-1:0]),
    .req_size  (req_size),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .align_err (align_err)
);

// File: tb/test_lane_mem_port.sv
module test_lane_mem_port;
    localparam int ROWS = 16;
    localparam int AW   = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic          req_swap = 1'b0;
    logic [63:0]   wr_data = '0;
    logic [63:0]   rd_data;
    logic          rd_valid;
    logic          align_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [63:0] mdl [ROWS];

    logic [63:0] q_data [$];
    logic        q_vld  [$];
    logic        q_err  [$];
    string       q_tag  [$];

    always #5 clk = ~clk;

    lane_mem_port #(.ROWS(ROWS)) i_lane_mem_port (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_swap(req_swap),
        .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
        .align_err(align_err)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: issue one request and push the predicted response
    task automatic op(bit wr, int addr, int sz, bit sw, logic [63:0] d, string tag);
        int nb, off, row;
        logic [63:0] e;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = AW'(addr);
        req_size = 2'(sz); req_swap = sw; wr_data = d;
        nb = 1 << sz; off = addr & 7; row = addr >> 3;
        e = '0;
        if ((off % nb) != 0) begin
            q_vld.push_back(1'b0); q_err.push_back(1'b1); q_data.push_back('0);
        end else if (wr) begin
            for (int i = 0; i < nb; i++)
                mdl[row][(off+i)*8 +: 8] = d[(sw ? nb-1-i : i)*8 +: 8];
            q_vld.push_back(1'b0); q_err.push_back(1'b0); q_data.push_back('0);
        end else begin
            for (int i = 0; i < nb; i++)
                e[(sw ? nb-1-i : i)*8 +: 8] = mdl[row][(off+i)*8 +: 8];
            q_vld.push_back(1'b1); q_err.push_back(1'b0); q_data.push_back(e);
        end
        q_tag.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    // monitor: compare each response one cycle after its request
    always @(posedge clk) begin
        if (!rst && req_valid) begin
            #1;
            if (q_tag.size() == 0) begin
                checks++; fails++;
                $display("FAIL scoreboard: actual response expected none");
            end else begin
                automatic string tg = q_tag.pop_front();
                check({tg, " rd_valid"}, 64'(rd_valid), 64'(q_vld.pop_front()));
                check({tg, " align_err"}, 64'(align_err), 64'(q_err.pop_front()));
                check({tg, " rd_data"}, rd_data, q_data.pop_front());
            end
        end
    end

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        for (int i = 0; i < ROWS; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check("R9 rd_data", rd_data, '0);
        check("R9 rd_valid", 64'(rd_valid), '0);
        check("R9 align_err", 64'(align_err), '0);
        op(0, 5*8, 3, 0, '0, "R9");
        // R10 full row write and read, plus swapped full read
        op(1, 2*8, 3, 0, 64'h1122334455667788, "R10");
        op(0, 2*8, 3, 0, '0, "R10");
        op(0, 2*8, 3, 1, '0, "R10");
        // R1 neighbouring row untouched
        op(1, 3*8, 3, 0, 64'hA5A5A5A5A5A5A5A5, "R1");
        op(0, 2*8, 3, 0, '0, "R1");
        op(0, 15*8 + 6, 1, 0, '0, "R1");
        // R5 / R11 byte store with junk upper data, R6 back-to-back
        op(1, 2*8 + 3, 0, 0, 64'hFFFFFFFF_FFFFFFAB, "R11");
        op(0, 2*8, 3, 0, '0, "R6");
        op(0, 2*8 + 3, 0, 0, '0, "R4");
        // R7 swapped half store, R8 swapped half load
        op(1, 2*8 + 4, 1, 1, 64'h0000_0000_0000_BEEF, "R7");
        op(0, 2*8 + 4, 1, 0, '0, "R7");
        op(0, 2*8 + 4, 1, 1, '0, "R8");
        op(0, 2*8 + 4, 2, 0, '0, "R4");
        op(1, 15*8 + 4, 2, 1, 64'h9999_9999_0102_0304, "R7");
        op(0, 15*8, 3, 0, '0, "R5");
        op(0, 15*8 + 4, 2, 1, '0, "R8");
        op(1, 4*8, 3, 1, 64'h0807060504030201, "R10");
        op(0, 4*8, 3, 0, '0, "R10");
        // R2 misaligned accesses refused, row unchanged
        op(1, 2*8 + 1, 1, 0, 64'hDEAD, "R2");
        op(0, 2*8, 3, 0, '0, "R2");
        op(0, 2*8 + 2, 2, 0, '0, "R2");
        op(0, 2*8 + 4, 3, 0, '0, "R2");
        op(1, 6*8 + 6, 2, 1, 64'h7, "R2");
        op(0, 6*8, 3, 0, '0, "R2");
        idle();
        idle();
        op(0, 3*8 + 2, 1, 0, '0, "R3");
        idle();
        // mixed pattern sweep
        lf = 32'hACE1_2468;
        for (int k = 0; k < 120; k++) begin
            int sz, nb, ad;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            sz = int'(lf[5:4]); nb = 1 << sz;
            ad = int'(lf[3:0]) * 8 + (int'(lf[8:6]) & ~(nb - 1));
            if (lf[9]) op(1, ad, sz, lf[10], {lf, ~lf}, "R5");
            else       op(0, ad, sz, lf[10], '0, "R4");
        end
        for (int r = 0; r < ROWS; r++) op(0, r*8, 3, 0, '0, "R5");
        idle();
        idle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule